// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Router

This block collects a parameterised number of level-sensitive peripheral interrupt lines and produces one interrupt request per CPU, each wired straight to a hardware interrupt pin of its CPU. Every CPU owns a private bank of registers: for each group of 32 lines it holds one enable word and one status word. A CPU only sees the lines it has enabled in its own bank. Any line can therefore go to any subset of CPUs, and the banks never affect one another.

There is no prioritisation, no encoding, no queue and no edge capture. A line is pending exactly while it is high. Software on a CPU finds its sources by reading every status word of its bank. It changes enables with whole-word writes, using read-modify-write. The raw lines pass through a two-flop synchroniser. Each CPU output is registered.

Top module: `lir_router`

## Requirements
- R1: After reset every enable word reads zero and every CPU output is low, whatever the input lines do.
- R2: Status bit n of word k in bank c reads as the synchronised level of line 32k+n ANDed with bank c's enable bit for that line. Read data appears in the cycle after the read strobe. Cycles without a read return zero.
- R3: Each CPU output is the OR of all status bits of its bank. It rises or falls three clock edges after an input line changes: two synchroniser edges and one output edge.
- R4: A write to an enable word replaces all 32 bits with the write data. Reading the word back returns exactly the written value.
- R5: Status words are read-only. Writes to them change no enable bit and no output.
- R6: A write to one CPU's bank leaves every other bank's enables and outputs unchanged.
- R7: The byte address of bank c's base is c·8·W, where W = lines/32. Enable word k sits at base+4k and status word k at base+4(W+k). Bit n of word k maps to line 32k+n.
- R8: Addresses beyond the last bank read as zero, and writes to them are ignored.
- R9: After an enable write on a line that is already high, the CPU output changes on the second clock edge after the write strobe is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Level-sensitive peripheral interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| cpu_irq | output | NUM_CPUS | One interrupt request per CPU |

## Verification
An input line change shows on a CPU output at the third rising edge. An enable write shows on the output at the second edge after the strobe. A read returns data at the first edge after the strobe. The bench changes inputs on falling edges and counts rising edges before it samples on the following falling edge. The directed cases check that the output is still low one edge before its due time and high at that time. The random phases leave four idle cycles after each change before they compare reads and outputs with the bench's own model.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int unsigned WORD_BITS = 32;

  // word slot inside one CPU bank (enables first, then status words)
  function automatic int unsigned slot_of(input logic [31:0] byte_addr,
                                          input int unsigned words);
    return (byte_addr >> 2) % (2 * words);
  endfunction

  // which CPU bank a byte address falls in
  function automatic int unsigned cpu_of(input logic [31:0] byte_addr,
                                         input int unsigned words);
    return (byte_addr >> 2) / (2 * words);
  endfunction
endpackage

// File: rtl/lir_sync.sv
module lir_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/lir_cpu_bank.sv
module lir_cpu_bank #(
  parameter int unsigned LINES = 64,
  localparam int unsigned WORDS = LINES / 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl,
  input  logic [WORDS-1:0] we_word,
  input  logic [31:0]      wdata,
  output logic [LINES-1:0] en,
  output logic [LINES-1:0] status,
  output logic             irq_out
);
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en[k*32 +: 32] <= '0;
      else if (we_word[k]) en[k*32 +: 32] <= wdata;
    end
  end

  assign status = lvl & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |status;
  end
endmodule

// File: rtl/lir_regif.sv
module lir_regif #(
  parameter int unsigned NUM_CPUS  = 2,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned WORDS    = NUM_LINES / 32,
  localparam int unsigned FLAT     = NUM_CPUS * NUM_LINES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [FLAT-1:0]           en_flat,
  input  logic [FLAT-1:0]           status_flat,
  output logic [NUM_CPUS*WORDS-1:0] wr_sel,
  output logic                      wr_status,
  output logic                      rd_miss,
  output logic [31:0]               rdata
);
  import lir_pkg::*;

  logic [31:0]  addr32;
  int unsigned  cpu_idx;
  int unsigned  slot;
  logic         in_range;
  logic         is_status;
  logic [31:0]  rd_word;

  assign addr32    = 32'(reg_addr);
  assign cpu_idx   = cpu_of(addr32, WORDS);
  assign slot      = slot_of(addr32, WORDS);
  assign in_range  = (cpu_idx < NUM_CPUS);
  assign is_status = (slot >= WORDS);
  assign wr_status = reg_wr && in_range && is_status;
  assign rd_miss   = reg_rd && !in_range;

  always_comb begin
    wr_sel = '0;
    if (reg_wr && in_range && !is_status)
      wr_sel[cpu_idx * WORDS + slot] = 1'b1;
  end

  always_comb begin
    rd_word = '0;
    if (in_range) begin
      if (is_status) rd_word = status_flat[(cpu_idx * WORDS + (slot - WORDS)) * 32 +: 32];
      else           rd_word = en_flat[(cpu_idx * WORDS + slot) * 32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (reg_rd) rdata <= rd_word;
    else             rdata <= '0;
  end
endmodule

// File: rtl/lir_router.sv
module lir_router #(
  parameter int unsigned NUM_CPUS  = 2,
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_CPUS-1:0]  cpu_irq
);
  localparam int unsigned WORDS = NUM_LINES / 32;
  localparam int unsigned FLAT  = NUM_CPUS * NUM_LINES;

  logic [NUM_LINES-1:0]      irq_sync;
  logic [FLAT-1:0]           en_flat;
  logic [FLAT-1:0]           status_flat;
  logic [NUM_CPUS*WORDS-1:0] wr_sel;
  logic                      wr_status;
  logic                      rd_miss;

  lir_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_lines), .q(irq_sync)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    lir_cpu_bank #(.LINES(NUM_LINES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (irq_sync),
      .we_word (wr_sel[c*WORDS +: WORDS]),
      .wdata   (reg_wdata),
      .en      (en_flat[c*NUM_LINES +: NUM_LINES]),
      .status  (status_flat[c*NUM_LINES +: NUM_LINES]),
      .irq_out (cpu_irq[c])
    );
  end

  lir_regif #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .en_flat(en_flat), .status_flat(status_flat),
    .wr_sel(wr_sel), .wr_status(wr_status), .rd_miss(rd_miss), .rdata(reg_rdata)
  );
endmodule

// File: rtl/lir_checker.sv
module lir_checker #(
  parameter int unsigned NUM_CPUS  = 2,
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned WORDS    = NUM_LINES / 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_LINES-1:0]          irq_sync,
  input logic [NUM_CPUS*NUM_LINES-1:0] en_flat,
  input logic [NUM_CPUS*WORDS-1:0]     wr_sel,
  input logic                          wr_status,
  input logic                          rd_miss,
  input logic [31:0]                   reg_wdata,
  input logic [31:0]                   reg_rdata,
  input logic [NUM_CPUS-1:0]           cpu_irq
);
  // R6: at most one enable word is written per cycle
  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R5: status writes leave every enable bit as it was
  assert_status_wr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> $stable(en_flat));

  // R6/R8: with no enable word selected, nothing changes
  assert_no_sel_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == '0) |=> $stable(en_flat));

  // R8: reads past the last bank return zero
  assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |=> (reg_rdata == 32'h0));

  for (genvar i = 0; i < NUM_CPUS * WORDS; i++) begin : g_word
    // R4: selected enable word takes the whole write value
    assert_enable_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] |=> (en_flat[i*32 +: 32] == $past(reg_wdata)));
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    // R3: output equals last cycle's OR of enabled synchronised levels
    assert_irq_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cpu_irq[c] == $past(|(irq_sync & en_flat[c*NUM_LINES +: NUM_LINES]))));
  end
endmodule

bind lir_router lir_checker #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_sync(irq_sync), .en_flat(en_flat),
  .wr_sel(wr_sel), .wr_status(wr_status), .rd_miss(rd_miss),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
);

// File: tb/tb_lir_router.sv
`timescale 1ns/1ps
module tb_lir_router;
  localparam int NC = 2;
  localparam int NL = 64;
  localparam int W  = NL / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_lines = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] cpu_irq;

  int n_checks = 0, n_fail = 0;
  logic [31:0] en_m [NC][W];
  bit done = 0;

  always #4 clk = ~clk;

  lir_router #(.NUM_CPUS(NC), .NUM_LINES(NL), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  function automatic logic [11:0] en_addr(int c, int k);  return 12'(c*8*W + 4*k);     endfunction
  function automatic logic [11:0] st_addr(int c, int k);  return 12'(c*8*W + 4*(W+k)); endfunction
  function automatic logic [31:0] exp_st(int c, int k);   return irq_lines[k*32 +: 32] & en_m[c][k]; endfunction
  function automatic logic exp_irq(int c);
    logic r = 0;
    for (int k = 0; k < W; k++) r |= |exp_st(c, k);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata; reg_rd = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      check({req, " cpu_irq"}, 32'(cpu_irq[c]), 32'(exp_irq(c)));
      for (int k = 0; k < W; k++) begin
        rd(en_addr(c, k), d); check({req, " enable"}, d, en_m[c][k]);
        rd(st_addr(c, k), d); check({req, " status"}, d, exp_st(c, k));
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int c = 0; c < NC; c++) for (int k = 0; k < W; k++) en_m[c][k] = '0;
    irq_lines = {NL{1'b1}};
    idle(3); rst_n = 1; idle(4);

    // R1: enables zero and outputs low despite every line high
    check("R1 cpu_irq", 32'(cpu_irq), 32'h0);
    check_all("R1");

    // R3 / R7: line 32+5 -> bank 0 word 1 bit 5; timing of output
    irq_lines = '0; idle(4);
    wr(en_addr(0, 1), 32'h0000_0020); en_m[0][1] = 32'h20;
    idle(2);
    irq_lines[37] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3 two edges still low", 32'(cpu_irq[0]), 32'h0);
    @(negedge clk);
    check("R3 third edge high", 32'(cpu_irq[0]), 32'h1);
    check("R6 other cpu low", 32'(cpu_irq[1]), 32'h0);
    rd(st_addr(0, 1), d); check("R7 status bit mapping", d, 32'h20);
    rd(st_addr(0, 0), d); check("R7 word0 clear", d, 32'h0);
    irq_lines[37] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3 fall two edges", 32'(cpu_irq[0]), 32'h1);
    @(negedge clk);
    check("R3 fall third edge", 32'(cpu_irq[0]), 32'h0);

    // R9: enable write on a line already high
    irq_lines[3] = 1'b1; idle(4);
    wr(en_addr(1, 0), 32'h0000_0008); en_m[1][0] = 32'h8;
    check("R9 first edge low", 32'(cpu_irq[1]), 32'h0);
    @(negedge clk);
    check("R9 second edge high", 32'(cpu_irq[1]), 32'h1);
    check("R6 cpu0 unaffected", 32'(cpu_irq[0]), 32'h0);

    // R5: status write ignored
    wr(st_addr(1, 0), 32'h0); idle(3);
    check("R5 output kept", 32'(cpu_irq[1]), 32'h1);
    rd(en_addr(1, 0), d); check("R5 enable kept", d, 32'h8);

    // R8: out-of-range bank
    wr(12'(NC*8*W), 32'hFFFF_FFFF); wr(12'(NC*8*W + 4), 32'hFFFF_FFFF);
    rd(12'(NC*8*W), d); check("R8 miss reads zero", d, 32'h0);
    idle(3);
    check_all("R8");

    // R4: full-word replace
    wr(en_addr(0, 0), 32'hA5A5_0F0F); en_m[0][0] = 32'hA5A5_0F0F;
    rd(en_addr(0, 0), d); check("R4 readback", d, 32'hA5A5_0F0F);
    wr(en_addr(0, 0), 32'h0000_0001); en_m[0][0] = 32'h1;
    rd(en_addr(0, 0), d); check("R4 replaced", d, 32'h1);

    // R2: no read -> rdata zero
    idle(1); check("R2 idle rdata", reg_rdata, 32'h0);

    // random phase: R2 R3 R4 R5 R6
    for (int it = 0; it < 150; it++) begin
      int c = $urandom_range(NC-1);
      int k = $urandom_range(W-1);
      logic [31:0] v = $urandom;
      case ($urandom_range(3))
        0: begin wr(en_addr(c, k), v); en_m[c][k] = v; end
        1: wr(st_addr(c, k), v);
        2: irq_lines = {$urandom, $urandom} & {$urandom, $urandom};
        default: irq_lines[$urandom_range(NL-1)] ^= 1'b1;
      endcase
      idle(4);
      check_all("R2 R3 R4 R6 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule